// File: doc/BRIEF.md
# Card Clock Divider Control

This block derives the clock driven to a memory card from the peripheral clock. A single 32-bit control word, written as a whole, holds an output enable, a 4-bit divider exponent and four timeout-select fields. The exponent picks a power-of-two division of the peripheral clock. Two codes, 0 and 15, select an undivided pass-through instead. Besides the card clock itself, the block drives a strobe that is high for one peripheral cycle at every card-clock rising edge, for use by the shift logic downstream.

The four timeout-select fields are registered and passed unchanged to the engines that own the timeout counters. A synchronous soft reset clears the whole word, so the clock stops and every field reads zero. Software is expected to reprogram the rate in four writes: first clear the enable, then clear the exponent, then write the new exponent, and finally set the enable again. The block makes sure that the output never shows a shortened high pulse when the enable changes.

Top module: `card_clk_div`

## Requirements
- R1: After `rst_ni` is released, `card_clk_o` and `card_rise_o` are low and all four timeout outputs are zero.
- R2: While the enable (bit 24) is 0, `card_clk_o` and `card_rise_o` stay low in both the divided and the pass-through modes.
- R3: With the enable set and a code n from 1 to 9 in bits 19:16, `card_clk_o` is high for 2^(n-1) peripheral cycles and then low for 2^(n-1) cycles, repeating.
- R4: Codes 0 and 15 pass the clock through. While enabled, `card_clk_o` is high during the high phase of `clk_i`, low during its low phase, and `card_rise_o` is high in every cycle.
- R5: Codes 10 to 14 divide by 512, the same as code 9.
- R6: The cycle after a write, the timeout outputs show the written bits: response timeout = bits 13:12, busy timeout = bits 11:8, data timeout = bits 7:4, completion timeout = bits 3:0. The undefined bits 31:25, 23:20 and 15:14 change nothing.
- R7: In a divided mode, `card_rise_o` is high for exactly the first peripheral cycle of each `card_clk_o` high phase and low in all other cycles.
- R8: A change of the enable takes effect only while the divided clock is low. Clearing the enable during a high phase lets that phase run to its full length, and the output then stays low.
- R9: After an enabling write to a stopped clock, `card_clk_o` first rises on the 2^(n-1)+1-th clock edge after the edge that captured the write. A write that changes the exponent restarts the phase counter from zero.
- R10: `soft_rst_i` clears the whole register, and it wins over a write in the same cycle. From the next cycle the timeout outputs are zero and `card_clk_o` and `card_rise_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| soft_rst_i | input | 1 | Synchronous clear of the control register |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 32 | Control word to write |
| card_clk_o | output | 1 | Card clock |
| card_rise_o | output | 1 | One-cycle strobe at each card-clock rising edge |
| rsp_to_sel_o | output | 2 | Response timeout select |
| busy_to_sel_o | output | 4 | Response-busy timeout select |
| data_to_sel_o | output | 4 | Read/write data timeout select |
| done_to_sel_o | output | 4 | Completion-signal timeout select |

## Verification
The bench builds the block with the default maximum exponent of 9. This makes the largest divider reachable: half periods of 256 cycles are measured directly, and codes 10, 12 and 14 are shown to saturate at that rate. Because the exponent range is small, every phase length can be counted cycle by cycle. This covers the single-cycle phases at code 1, the exponent restart in the middle of a low phase, and a disable issued during a high phase.

// File: rtl/ccd_pkg.sv
package ccd_pkg;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned EN_BIT   = 24;
  localparam int unsigned DIV_LSB  = 16;
  localparam int unsigned DIV_W    = 4;
  localparam int unsigned RSP_LSB  = 12;
  localparam int unsigned RSP_W    = 2;
  localparam int unsigned BSY_LSB  = 8;
  localparam int unsigned DAT_LSB  = 4;
  localparam int unsigned DONE_LSB = 0;
  localparam int unsigned SEL_W    = 4;

  localparam logic [DIV_W-1:0] CODE_DIRECT = 4'h0;
  localparam logic [DIV_W-1:0] CODE_BYPASS = 4'hF;

  typedef struct packed {
    logic             en;
    logic [DIV_W-1:0] div;
    logic [RSP_W-1:0] rsp;
    logic [SEL_W-1:0] bsy;
    logic [SEL_W-1:0] dat;
    logic [SEL_W-1:0] done;
  } clk_ctrl_t;
endpackage

// File: rtl/ccd_ctrl_reg.sv
module ccd_ctrl_reg
  import ccd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             soft_rst_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output clk_ctrl_t        ctrl_o,
  output logic             div_chg_o
);
  clk_ctrl_t ctrl_q, ctrl_d;
  logic      unused_rsvd;

  always_comb begin
    ctrl_d.en   = wr_data_i[EN_BIT];
    ctrl_d.div  = wr_data_i[DIV_LSB +: DIV_W];
    ctrl_d.rsp  = wr_data_i[RSP_LSB +: RSP_W];
    ctrl_d.bsy  = wr_data_i[BSY_LSB +: SEL_W];
    ctrl_d.dat  = wr_data_i[DAT_LSB +: SEL_W];
    ctrl_d.done = wr_data_i[DONE_LSB +: SEL_W];
  end

  assign unused_rsvd = ^{wr_data_i[REG_W-1:EN_BIT+1],
                         wr_data_i[EN_BIT-1:DIV_LSB+DIV_W],
                         wr_data_i[DIV_LSB-1:RSP_LSB+RSP_W]};

  assign div_chg_o = wr_en_i && !soft_rst_i && (ctrl_d.div != ctrl_q.div);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         ctrl_q <= '0;
    else if (soft_rst_i) ctrl_q <= '0;
    else if (wr_en_i)    ctrl_q <= ctrl_d;
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/ccd_div_core.sv
module ccd_div_core #(
  parameter int unsigned MAX_EXP = 9
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       restart_i,
  input  logic       run_i,
  input  logic [3:0] exp_i,
  output logic       div_o,
  output logic       rise_o,
  output logic       active_o
);
  localparam int unsigned CNT_W = (MAX_EXP > 1) ? MAX_EXP - 1 : 1;

  logic [CNT_W-1:0] cnt_q, lim;
  logic [CNT_W:0]   half;
  logic             div_q, rise_q, act_q;

  // half period 2^(exp-1); terminal count is half-1
  assign half = (CNT_W+1)'(1) << (exp_i - 4'd1);
  assign lim  = half[CNT_W-1:0] - CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0; div_q <= 1'b0; rise_q <= 1'b0; act_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0; div_q <= 1'b0; rise_q <= 1'b0; act_q <= 1'b0;
    end else begin
      rise_q <= 1'b0;
      if (!act_q) begin
        cnt_q <= '0;
        div_q <= 1'b0;
        if (run_i) act_q <= 1'b1;
      end else if (!run_i && !div_q) begin
        act_q <= 1'b0;
        cnt_q <= '0;
      end else if (restart_i) begin
        cnt_q <= '0;
      end else if (cnt_q == lim) begin
        cnt_q  <= '0;
        div_q  <= ~div_q;
        rise_q <= ~div_q;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign div_o    = div_q;
  assign rise_o   = rise_q;
  assign active_o = act_q;
endmodule

// File: rtl/ccd_clk_out.sv
module ccd_clk_out (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic byp_i,
  input  logic en_i,
  input  logic div_i,
  input  logic rise_i,
  output logic card_clk_o,
  output logic card_rise_o,
  output logic byp_sel_o
);
  logic byp_q, gate_q;

  // falling-edge capture: gate and select only move while clk_i is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byp_q  <= 1'b0;
      gate_q <= 1'b0;
    end else begin
      byp_q  <= byp_i;
      gate_q <= byp_i & en_i;
    end
  end

  assign card_clk_o  = byp_q ? (clk_i & gate_q) : div_i;
  assign card_rise_o = byp_q ? gate_q : rise_i;
  assign byp_sel_o   = byp_q;
endmodule

// File: rtl/card_clk_div.sv
module card_clk_div
  import ccd_pkg::*;
#(
  parameter int unsigned MAX_EXP = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             soft_rst_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic             card_clk_o,
  output logic             card_rise_o,
  output logic [RSP_W-1:0] rsp_to_sel_o,
  output logic [SEL_W-1:0] busy_to_sel_o,
  output logic [SEL_W-1:0] data_to_sel_o,
  output logic [SEL_W-1:0] done_to_sel_o
);
  clk_ctrl_t        ctrl;
  logic             div_chg, bypass, div_clk, div_rise, core_act, byp_sel;
  logic [DIV_W-1:0] exp_eff, div_code;

  ccd_ctrl_reg u_reg (
    .clk_i, .rst_ni, .soft_rst_i, .wr_en_i, .wr_data_i,
    .ctrl_o    (ctrl),
    .div_chg_o (div_chg)
  );

  assign div_code = ctrl.div;
  assign bypass   = (div_code == CODE_DIRECT) || (div_code == CODE_BYPASS);

  always_comb begin
    if (bypass)                          exp_eff = 4'd1;
    else if (div_code > DIV_W'(MAX_EXP)) exp_eff = DIV_W'(MAX_EXP);
    else                                 exp_eff = div_code;
  end

  ccd_div_core #(.MAX_EXP(MAX_EXP)) u_core (
    .clk_i, .rst_ni,
    .clr_i     (soft_rst_i),
    .restart_i (div_chg),
    .run_i     (ctrl.en & ~bypass),
    .exp_i     (exp_eff),
    .div_o     (div_clk),
    .rise_o    (div_rise),
    .active_o  (core_act)
  );

  ccd_clk_out u_out (
    .clk_i, .rst_ni,
    .byp_i       (bypass),
    .en_i        (ctrl.en),
    .div_i       (div_clk),
    .rise_i      (div_rise),
    .card_clk_o,
    .card_rise_o,
    .byp_sel_o   (byp_sel)
  );

  assign rsp_to_sel_o  = ctrl.rsp;
  assign busy_to_sel_o = ctrl.bsy;
  assign data_to_sel_o = ctrl.dat;
  assign done_to_sel_o = ctrl.done;
endmodule

// File: rtl/card_clk_div_chk.sv
module card_clk_div_chk #(
  parameter int unsigned MAX_EXP = 9
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        soft_rst_i,
  input logic        wr_en_i,
  input logic [31:0] wr_data_i,
  input logic        card_clk_o,
  input logic        card_rise_o,
  input logic [1:0]  rsp_to_sel_o,
  input logic [3:0]  busy_to_sel_o,
  input logic [3:0]  data_to_sel_o,
  input logic [3:0]  done_to_sel_o,
  input logic        byp_sel_i,
  input logic        act_i,
  input logic [3:0]  code_i
);
  logic [15:0] hi_len, need;

  function automatic logic [15:0] half_of(input logic [3:0] c);
    if (c == 4'h0 || c == 4'hF) return 16'd1;
    else if (c > 4'(MAX_EXP))   return 16'd1 << (MAX_EXP - 1);
    else                        return 16'd1 << (c - 4'd1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_len <= '0;
      need   <= '0;
    end else if (!byp_sel_i && card_clk_o) begin
      hi_len <= hi_len + 16'd1;
      if (card_rise_o)                need <= half_of(code_i);
      else if (half_of(code_i) < need) need <= half_of(code_i);
    end else begin
      hi_len <= '0;
    end
  end

  assert_fields_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !soft_rst_i |=> rsp_to_sel_o == $past(wr_data_i[13:12]) &&
      busy_to_sel_o == $past(wr_data_i[11:8]) &&
      data_to_sel_o == $past(wr_data_i[7:4]) &&
      done_to_sel_o == $past(wr_data_i[3:0]));

  assert_soft_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> rsp_to_sel_o == 2'd0 && busy_to_sel_o == 4'd0 &&
      data_to_sel_o == 4'd0 && done_to_sel_o == 4'd0 && !card_rise_o && !act_i);

  assert_stop_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byp_sel_i && !act_i |-> !card_clk_o);

  assert_rise_in_high_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byp_sel_i && card_rise_o |-> card_clk_o);

  assert_rise_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byp_sel_i && card_rise_o |=> byp_sel_i || !card_rise_o);

  assert_full_high_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byp_sel_i && !card_clk_o && hi_len != 16'd0 && !$past(soft_rst_i)
      |-> hi_len >= need);
endmodule

bind card_clk_div card_clk_div_chk #(.MAX_EXP(MAX_EXP)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .soft_rst_i    (soft_rst_i),
  .wr_en_i       (wr_en_i),
  .wr_data_i     (wr_data_i),
  .card_clk_o    (card_clk_o),
  .card_rise_o   (card_rise_o),
  .rsp_to_sel_o  (rsp_to_sel_o),
  .busy_to_sel_o (busy_to_sel_o),
  .data_to_sel_o (data_to_sel_o),
  .done_to_sel_o (done_to_sel_o),
  .byp_sel_i     (byp_sel),
  .act_i         (core_act),
  .code_i        (div_code)
);

// File: tb/card_clk_div_tb_top.sv
module card_clk_div_tb_top;
  logic        clk = 1'b0;
  logic        rst_n, soft_rst, wr_en;
  logic [31:0] wr_data;
  logic        card_clk, card_rise;
  logic [1:0]  rsp_sel;
  logic [3:0]  bsy_sel, dat_sel, done_sel;

  int    n_chk = 0;
  int    n_fail = 0;
  int    exp_q[$];
  string mon_tag = "";
  logic  mon_sync = 1'b0;
  logic [3:0] cur_code = 4'h0;

  always #5 clk = ~clk;

  card_clk_div dut_i (
    .clk_i (clk), .rst_ni (rst_n), .soft_rst_i (soft_rst),
    .wr_en_i (wr_en), .wr_data_i (wr_data),
    .card_clk_o (card_clk), .card_rise_o (card_rise),
    .rsp_to_sel_o (rsp_sel), .busy_to_sel_o (bsy_sel),
    .data_to_sel_o (dat_sel), .done_to_sel_o (done_sel)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  // all driver tasks start and end at posedge+1
  task automatic wr_raw(input logic [31:0] d);
    wr_data = d;
    wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic wr(input logic en, input logic [3:0] code, input logic [13:0] tos);
    wr_raw({7'h00, en, 4'h0, code, 2'b00, tos});
  endtask

  task automatic stop_and_load(input logic [3:0] code);
    wr(1'b0, cur_code, 14'h0);
    repeat (600) @(posedge clk);
    #1;
    wr(1'b0, 4'h0, 14'h0);
    wr(1'b0, code, 14'h0);
    cur_code = code;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic check_rate(input logic [3:0] code, input int half, input string tag);
    stop_and_load(code);
    wr(1'b1, code, 14'h0);
    mon_tag = tag;
    repeat (4) exp_q.push_back(half);
    mon_sync = 1'b1;
    while (exp_q.size() > 0) step();
    mon_sync = 1'b0;
  endtask

  task automatic count_high(input int cycles, input string tag);
    int hi;
    hi = 0;
    for (int i = 0; i < cycles; i++) begin
      if (card_clk !== 1'b0 || card_rise !== 1'b0) hi++;
      step();
    end
    chk(tag, hi, 0);
  endtask

  task automatic check_bypass(input logic [3:0] code, input string tag);
    stop_and_load(code);
    wr(1'b1, code, 14'h0);
    repeat (3) @(posedge clk);
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #2;
      chk({tag, " clk high phase"}, card_clk, 1);
      chk({tag, " strobe"}, card_rise, 1);
      @(negedge clk); #2;
      chk({tag, " clk low phase"}, card_clk, 0);
    end
    @(posedge clk); #1;
    wr(1'b0, code, 14'h0);
    repeat (2) @(posedge clk);
    @(posedge clk); #2;
    chk("R2 bypass stopped high phase", card_clk, 0);
    chk("R2 bypass stopped strobe", card_rise, 0);
    @(negedge clk); #2;
    chk("R2 bypass stopped low phase", card_clk, 0);
    @(posedge clk); #1;
  endtask

  // monitor: measures complete card-clock phases against the queue
  initial begin
    logic prev;
    int   run;
    logic armed;
    prev = 1'b0; run = 0; armed = 1'b0;
    forever begin
      @(posedge clk); #2;
      if (!mon_sync) armed = 1'b0;
      if (card_clk !== prev) begin
        if (armed && exp_q.size() > 0) chk(mon_tag, run, exp_q.pop_front());
        if (mon_sync) armed = 1'b1;
        run = 1;
        if (armed && card_clk) chk("R7 strobe at rise", card_rise, 1);
      end else begin
        run++;
        if (armed) chk("R7 strobe off", card_rise, 0);
      end
      prev = card_clk;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0; soft_rst = 1'b0; wr_en = 1'b0; wr_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2;
    chk("R1 clk after reset", card_clk, 0);
    chk("R1 strobe after reset", card_rise, 0);
    chk("R1 fields after reset", {rsp_sel, bsy_sel, dat_sel, done_sel}, 0);
    @(negedge clk); #2;
    chk("R1 clk low phase", card_clk, 0);
    @(posedge clk); #1;

    // R6 field export and ignored bits
    wr(1'b0, 4'h0, 14'h2A5C);
    chk("R6 rsp", rsp_sel, 2);
    chk("R6 busy", bsy_sel, 10);
    chk("R6 data", dat_sel, 5);
    chk("R6 done", done_sel, 12);
    wr_raw(32'hFEF0_C000);
    chk("R6 undefined bits", {rsp_sel, bsy_sel, dat_sel, done_sel}, 0);
    count_high(10, "R2 undefined bits keep clock stopped");

    // R9 first rise latency
    stop_and_load(4'd4);
    wr(1'b1, 4'd4, 14'h0);
    n = 0;
    while (card_clk === 1'b0 && n < 1000) begin n++; step(); end
    chk("R9 first low phase code 4", n, 9);
    stop_and_load(4'd1);
    wr(1'b1, 4'd1, 14'h0);
    n = 0;
    while (card_clk === 1'b0 && n < 1000) begin n++; step(); end
    chk("R9 first low phase code 1", n, 2);

    // R3 / R5 rates
    check_rate(4'd1, 1, "R3 code 1 phase");
    check_rate(4'd2, 2, "R3 code 2 phase");
    check_rate(4'd5, 16, "R3 code 5 phase");
    check_rate(4'd9, 256, "R3 code 9 phase");
    check_rate(4'd10, 256, "R5 code 10 phase");
    check_rate(4'd12, 256, "R5 code 12 phase");
    check_rate(4'd14, 256, "R5 code 14 phase");

    // R8 disable during high phase
    stop_and_load(4'd3);
    wr(1'b1, 4'd3, 14'h0);
    while (card_rise !== 1'b1) step();
    wr(1'b0, 4'd3, 14'h0);
    n = 1;
    while (card_clk === 1'b1 && n < 1000) begin n++; step(); end
    chk("R8 high phase length after disable", n, 4);
    count_high(30, "R8 stays low after disable");

    // R9 exponent change restarts the counter mid low phase
    stop_and_load(4'd5);
    wr(1'b1, 4'd5, 14'h0);
    while (card_rise !== 1'b1) step();
    while (card_clk !== 1'b0) step();
    wr(1'b1, 4'd1, 14'h0);
    cur_code = 4'd1;
    n = 0;
    while (card_clk === 1'b0 && n < 1000) begin n++; step(); end
    chk("R9 restart low remainder", n, 1);
    n = 0;
    while (card_clk === 1'b1 && n < 1000) begin n++; step(); end
    chk("R9 restart new high phase", n, 1);

    // R4 pass-through codes
    check_bypass(4'hF, "R4 code 15");
    check_bypass(4'h0, "R4 code 0");

    // R10 soft reset beats a write
    stop_and_load(4'd2);
    wr(1'b1, 4'd2, 14'h3FFF);
    repeat (20) step();
    soft_rst = 1'b1;
    wr_data = {7'h00, 1'b1, 4'h0, 4'd5, 2'b00, 14'h1111};
    wr_en = 1'b1;
    step();
    soft_rst = 1'b0;
    wr_en = 1'b0;
    chk("R10 fields cleared", {rsp_sel, bsy_sel, dat_sel, done_sel}, 0);
    chk("R10 clock low", card_clk, 0);
    chk("R10 strobe low", card_rise, 0);
    count_high(20, "R10 clock stays stopped");

    summary();
    $finish;
  end
endmodule